// File: doc/BRIEF.md
# Synthesizer Serial Register Port

This block is the serial control port of a frequency-synthesizer device. A host sends 32-bit frames bit by bit on a data input. Each bit is taken on a rising edge of the serial clock while the active-low select is held low. The frame is decoded when the select returns high. A frame whose 3-bit device-address field matches this device is written into a register file of 32 entries of 24 bits. Register 0 is the read pointer, and register 8 enables or disables the output driver.

Reads take two frames. The first frame writes the address of the target register into the pointer. During the next frame, the first serial-clock rising edge puts the lock-status input on the shared output. The following 32 edges put the read word on the same output. The same output pin shows the lock status until the first accepted frame. After that it stays on the serial read path and keeps driving the last bit shifted out. A complete frame addressed to another device releases the pin until a frame for this device arrives.

The serial inputs are sampled by the chip clock through a synchronizer. The block drives a data output and a separate output-enable for the external pad.

Top module: `synth_regport`

## Requirements
- R1: A frame is taken MSB first, with 24 data bits, then a 5-bit register address, then a 3-bit device address. When the select rises after exactly 32 serial-clock rising edges and the device address is 000, the data is stored in the addressed register.
- R2: A frame whose device address is not 000 writes no register.
- R3: A frame with any edge count other than 32 writes no register and does not change the state of the output pin.
- R4: After reset, `sdo` follows `lock_in`, and `sdo_oe` is 1.
- R5: During the frame after the pointer (register 0) is set to k, rising edge 1 outputs `lock_in`. Edges 2 to 33 output, MSB first, the 32-bit read word {k[4:0], 3'b000, register k}. The output changes on each rising edge.
- R6: Between frames, the pin keeps driving the last bit shifted out, with `sdo_oe` high.
- R7: When a frame with 32 edges and a non-zero device address ends, `sdo_oe` drops to 0. It stays low until a frame for this device ends.
- R8: While register 8 holds zero, `sdo_oe` is 0 whatever other condition applies. Writing a non-zero value restores it.
- R9: The choice between lock status and read data changes only when a frame ends, never in the middle of a frame.
- R10: After reset, every register reads 0 except register 8, which reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| sen | input | 1 | Active-low frame select; its rising edge ends a frame |
| sdi | input | 1 | Serial data from the host |
| lock_in | input | 1 | Lock status, high when locked |
| sdo | output | 1 | Shared lock/read-data output |
| sdo_oe | output | 1 | Output enable for the pad driver |

## Verification
On every cycle, the assertions check these things:
- each accepted write lands in the register file on the next cycle;
- the edge counter clears at frame start;
- the lock bit leads every read frame;
- the pin selection holds steady while no frame ends;
- the driver is off after a foreign-address frame, and whenever register 8 is zero.

Some behaviour can be shown only by the bench's scenarios. These are the full MSB-first read word for every register after a sweep of writes, the discarding of short frames, the recovery of the driver after a matching frame, and the reset contents read back through the port.

// File: rtl/synth_regport_pkg.sv
package synth_regport_pkg;

   // Source shown on the shared output pin
   typedef enum logic [1:0] {
      PIN_LOCK = 2'd0,   // lock status passthrough (after reset)
      PIN_READ = 2'd1,   // serial read path
      PIN_OFF  = 2'd2    // released after a foreign-address frame
   } pin_mode_e;

endpackage

// File: rtl/srp_sampler.sv
module srp_sampler #(
   parameter int          W      = 2,
   parameter int          STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("srp_sampler: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [W-1:0] s0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s0 <= RST_VAL;
         else        s0 <= din;
      end
      assign q = s0;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL}};
         else        chain <= {chain[STAGES-2:0], din};
      end
      assign q = chain[STAGES-1];
   end

endmodule

// File: rtl/srp_frame_rx.sv
module srp_frame_rx #(
   parameter int FRAME_W = 32,
   parameter int ADDR_W  = 5,
   parameter int CHIP_W  = 3,
   parameter int MY_CHIP = 0,
   parameter int CNT_W   = 6,
   localparam int DATA_W = FRAME_W - ADDR_W - CHIP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_strobe,  // qualified sck rise inside a frame
   input  logic              sdi_bit,
   input  logic              frame_start,
   input  logic              frame_end,
   output logic [CNT_W-1:0]  cnt,
   output logic              frame_full,
   output logic              chip_hit,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);

   localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
   localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CHIP_W-1:0] CHIP_ME  = CHIP_W'(MY_CHIP);

   logic [FRAME_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         shreg <= '0;
      end else if (frame_start) begin
         cnt <= '0;
      end else if (bit_strobe) begin
         shreg <= {shreg[FRAME_W-2:0], sdi_bit};
         if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
   end

   assign frame_full = (cnt == CNT_FULL);
   assign chip_hit   = (shreg[CHIP_W-1:0] == CHIP_ME);
   assign wr_addr    = shreg[CHIP_W +: ADDR_W];
   assign wr_data    = shreg[FRAME_W-1 -: DATA_W];
   assign wr_en      = frame_end & frame_full & chip_hit;

   // R3: every frame starts counting from zero
   assert_cnt_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (cnt == '0));

endmodule

// File: rtl/srp_regfile.sv
module srp_regfile #(
   parameter int          ADDR_W  = 5,
   parameter int          DATA_W  = 24,
   parameter int          PTR_IDX = 0,
   parameter int          CFG_IDX = 8,
   parameter logic [23:0] CFG_RST = 24'h1,
   localparam int DEPTH = 2 ** ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [ADDR_W-1:0] ptr,
   output logic [DATA_W-1:0] cfg,
   output logic [DATA_W-1:0] rd_data
);

   if (PTR_IDX >= DEPTH || CFG_IDX >= DEPTH || PTR_IDX == CFG_IDX) begin : g_bad_idx
      $error("srp_regfile: pointer and config indices must be distinct and in range");
   end

   logic [DEPTH-1:0][DATA_W-1:0] regs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            regs[i] <= (i == CFG_IDX) ? DATA_W'(CFG_RST) : '0;
      end else if (wr_en) begin
         regs[wr_addr] <= wr_data;
      end
   end

   assign ptr     = regs[PTR_IDX][ADDR_W-1:0];
   assign cfg     = regs[CFG_IDX];
   assign rd_data = regs[ptr];

   // R1: an accepted write is visible in the addressed entry one cycle later
   assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (regs[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/srp_read_tx.sv
module srp_read_tx #(
   parameter int FRAME_W = 32,
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 24,
   parameter int CNT_W   = 6,
   localparam int PAD_W  = FRAME_W - ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snap,        // frame start: capture read word
   input  logic              bit_strobe,  // qualified sck rise
   input  logic [CNT_W-1:0]  cnt,         // edges already seen in this frame
   input  logic              lock_in,
   input  logic [ADDR_W-1:0] ptr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              sdo_bit
);

   logic [FRAME_W-1:0] word_q;
   logic [FRAME_W-1:0] word_d;
   int                 idx;

   if (PAD_W > 0) begin : g_pad
      assign word_d = {ptr, {PAD_W{1'b0}}, rd_data};
   end else begin : g_nopad
      assign word_d = {ptr, rd_data};
   end

   always_comb idx = FRAME_W - int'(cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         sdo_bit <= 1'b0;
      end else begin
         if (snap) word_q <= word_d;
         if (bit_strobe) begin
            if (cnt == '0)
               sdo_bit <= lock_in;
            else if (idx >= 0)
               sdo_bit <= word_q[idx[$clog2(FRAME_W)-1:0]];
         end
      end
   end

   // R5: the first edge of a frame presents the lock status
   assert_lock_leads_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_strobe && cnt == '0) |=> (sdo_bit == $past(lock_in)));

endmodule

// File: rtl/synth_regport.sv
module synth_regport #(
   parameter int          FRAME_W     = 32,
   parameter int          ADDR_W      = 5,
   parameter int          CHIP_W      = 3,
   parameter int          MY_CHIP     = 0,
   parameter int          PTR_IDX     = 0,
   parameter int          CFG_IDX     = 8,
   parameter logic [23:0] CFG_RST     = 24'h1,
   parameter int          SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic sen,
   input  logic sdi,
   input  logic lock_in,
   output logic sdo,
   output logic sdo_oe
);
   import synth_regport_pkg::*;

   localparam int DATA_W = FRAME_W - ADDR_W - CHIP_W;
   localparam int CNT_W  = $clog2(FRAME_W + 2);

   if (DATA_W < 1 || FRAME_W > 64) begin : g_bad_frame
      $error("synth_regport: frame must hold data, address and chip fields");
   end

   // ---------------- input sampling and edge detection ----------------
   logic [2:0] pins_q;
   logic       sck_q, sen_q, sdi_q, sck_p, sen_p;
   logic       sck_rise, sen_rise, sen_fall, bit_strobe;

   srp_sampler #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sampler (
      .clk(clk), .rst_n(rst_n), .din({sck, sen, sdi}), .q(pins_q));

   assign {sck_q, sen_q, sdi_q} = pins_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_p <= 1'b0;
         sen_p <= 1'b1;
      end else begin
         sck_p <= sck_q;
         sen_p <= sen_q;
      end
   end

   assign sck_rise   = sck_q & ~sck_p;
   assign sen_rise   = sen_q & ~sen_p;
   assign sen_fall   = ~sen_q & sen_p;
   assign bit_strobe = sck_rise & ~sen_q;

   // ---------------- frame receiver ----------------
   logic [CNT_W-1:0]  cnt;
   logic              frame_full, chip_hit, wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;

   srp_frame_rx #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .CHIP_W(CHIP_W),
                  .MY_CHIP(MY_CHIP), .CNT_W(CNT_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .sdi_bit(sdi_q),
      .frame_start(sen_fall), .frame_end(sen_rise), .cnt(cnt),
      .frame_full(frame_full), .chip_hit(chip_hit), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data));

   // ---------------- register file ----------------
   logic [ADDR_W-1:0] ptr;
   logic [DATA_W-1:0] cfg_val, rd_data;

   srp_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_IDX(PTR_IDX),
                 .CFG_IDX(CFG_IDX), .CFG_RST(CFG_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ptr(ptr), .cfg(cfg_val), .rd_data(rd_data));

   // ---------------- read shifter ----------------
   logic rd_bit;

   srp_read_tx #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                 .CNT_W(CNT_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .snap(sen_fall), .bit_strobe(bit_strobe),
      .cnt(cnt), .lock_in(lock_in), .ptr(ptr), .rd_data(rd_data),
      .sdo_bit(rd_bit));

   // ---------------- pin mode, mux select and enable ----------------
   pin_mode_e mode_q;
   logic      oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= PIN_LOCK;
         oe_q   <= (CFG_RST != '0);
      end else begin
         if (sen_rise && frame_full)
            mode_q <= chip_hit ? PIN_READ : PIN_OFF;
         oe_q <= (mode_q != PIN_OFF) && (cfg_val != '0);
      end
   end

   assign sdo    = (mode_q == PIN_READ) ? rd_bit : lock_in;
   assign sdo_oe = oe_q;

   // R9: pin source only moves at a frame end
   assert_sel_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !sen_rise |=> $stable(mode_q));

   // R7: a complete foreign-address frame releases the pin
   assert_release_foreign_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sen_rise && frame_full && !chip_hit) |=> ##1 !sdo_oe);

   // R8: zero in the driver-enable register overrides everything
   assert_cfg_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_val == '0) |=> !sdo_oe);

endmodule

// File: tb/tb_synth_regport.sv
module tb_synth_regport;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0;
   logic sen = 1'b1;
   logic sdi = 1'b0;
   logic lock_in = 1'b1;
   logic sdo, sdo_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   synth_regport dut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .sen(sen), .sdi(sdi),
      .lock_in(lock_in), .sdo(sdo), .sdo_oe(sdo_oe));

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [23:0] d, input logic [4:0] a, input logic [2:0] c);
      return {d, a, c};
   endfunction

   function automatic logic [23:0] pat(input int k);
      logic [31:0] v;
      v = (k + 1) * 32'h0001F3C1;
      return v[23:0];
   endfunction

   function automatic logic [32:0] exp_rd(input logic lk, input int k, input logic [23:0] d);
      logic [4:0] a;
      a = k[4:0];
      return {lk, a, 3'b000, d};
   endfunction

   // n rising edges; sdo sampled after each edge, edge i into bit 32-i
   task automatic frame(input logic [31:0] w, input int n, output logic [32:0] got);
      got = '0;
      sen = 1'b0;
      wait_clk(4);
      for (int i = 0; i < n; i++) begin
         sdi = (i < 32) ? w[31 - i] : 1'b0;
         wait_clk(4);
         sck = 1'b1;
         wait_clk(4);
         if (i < 33) got[32 - i] = sdo;
         sck = 1'b0;
      end
      wait_clk(4);
      sen = 1'b1;
      wait_clk(8);
   endtask

   task automatic read_reg(input int k, input logic lk, output logic [32:0] got);
      logic [32:0] dummy;
      frame(mk(24'(k), 5'd0, 3'd0), 32, dummy);
      lock_in = lk;
      frame(32'h0, 33, got);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [32:0] got;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);

      // R4: reset state, pin shows lock status
      check("R4 oe after reset", sdo_oe, 1);
      lock_in = 1'b0; #1;
      check("R4 sdo follows lock low", sdo, 0);
      lock_in = 1'b1; #1;
      check("R4 sdo follows lock high", sdo, 1);

      // R9: pin stays on lock status through the whole first frame
      frame(mk(24'd8, 5'd0, 3'd0), 32, got);
      check("R9 lock held mid-frame", got[32:1], 32'hFFFF_FFFF);

      // R10 and R5: reset contents of register 8 and register 3
      lock_in = 1'b0;
      frame(32'h0, 33, got);
      check("R10 cfg reset", got, exp_rd(1'b0, 8, 24'h1));
      read_reg(3, 1'b1, got);
      check("R10 reg3 reset", got, exp_rd(1'b1, 3, 24'h0));

      // R1 sweep: write every register 1..31
      for (int k = 1; k < 32; k++) frame(mk(pat(k), 5'(k), 3'd0), 32, got);
      // R5: read every register back through the two-part read
      for (int k = 1; k < 32; k++) begin
         read_reg(k, k[0], got);
         check("R1 R5 readback", got, exp_rd(k[0], k, pat(k)));
      end

      // R6: pin keeps last read bit between frames, independent of lock
      lock_in = ~pat(31)[0];
      wait_clk(6);
      check("R6 hold last bit", sdo, pat(31)[0]);
      check("R6 oe held", sdo_oe, 1);

      // R7 and R2: foreign device address releases the pin, writes nothing
      frame(mk(~pat(4), 5'd4, 3'd5), 32, got);
      check("R7 oe released", sdo_oe, 0);
      frame(mk(24'd4, 5'd0, 3'd0), 32, got);
      check("R7 oe restored", sdo_oe, 1);
      lock_in = 1'b1;
      frame(32'h0, 33, got);
      check("R2 no write", got, exp_rd(1'b1, 4, pat(4)));

      // R3: short frames discarded, foreign short frame keeps pin
      frame(mk(24'h123456, 5'd6, 3'd0), 31, got);
      frame(mk(24'h654321, 5'd6, 3'd7), 31, got);
      check("R3 oe unchanged", sdo_oe, 1);
      frame(mk(24'hABCDEF, 5'd6, 3'd0), 33, got);
      read_reg(6, 1'b0, got);
      check("R3 no write", got, exp_rd(1'b0, 6, pat(6)));

      // R8: zero in register 8 turns the driver off over everything
      frame(mk(24'h0, 5'd8, 3'd0), 32, got);
      check("R8 oe off", sdo_oe, 0);
      frame(mk(24'd8, 5'd0, 3'd0), 32, got);
      check("R8 oe off after valid frame", sdo_oe, 0);
      frame(mk(24'h000001, 5'd8, 3'd0), 32, got);
      check("R8 oe restored", sdo_oe, 1);
      read_reg(8, 1'b1, got);
      check("R8 cfg readback", got, exp_rd(1'b1, 8, 24'h1));

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule